// File: doc/BRIEF.md
# Over-Current Pulse-Skip Protection Timer

This block sits in the digital control path of a synchronous buck converter. Its clock is the switching clock, so one clock period equals one switching cycle. At the start of every cycle it looks at a current-limit detect flag that the analog sensing path provides. When the flag is seen with the timer idle, the high-side pulse of that cycle is suppressed at once. The pulse is then also suppressed for a fixed skip window of the following cycles.

After the skip window the timer opens an observation window of equal default length. In that window the high-side pulses run normally while the flag is watched. A detect inside the observation window sets a sticky over-current latch. The latch shuts the high-side drive off and requests that power-good be pulled low. If the observation window ends cleanly, the timer returns to idle with its cycle count cleared, and the next detect begins a new sequence.

The latch clears when the enable input is taken low (the first half of an enable toggle) or when the supply is cycled, which is the active-low reset. Enable low also keeps the high-side drive off and makes the timer ignore the detect flag.

Top module: `oc_skip_guard`

## Requirements
- R1: After reset, with enable high and the detect flag low, hs_inhibit, oc_latch and pg_low_req are all 0.
- R2: With the timer idle and enable high, a detect flag of 1 drives hs_inhibit to 1 in that same cycle, before any clock edge, and starts a sequence. The detect cycle is cycle 0.
- R3: In cycles 1 through 8 after the detect cycle (SKIP_CYCLES, default 8), hs_inhibit is 1 whatever the detect flag does.
- R4: In cycles 9 through 16 (the WATCH_CYCLES observation window), hs_inhibit is 0 while the detect flag is 0.
- R5: A detect flag of 1 in any cycle of the observation window drives hs_inhibit to 1 in that cycle. It also sets oc_latch at the clock edge that ends that cycle. pg_low_req equals oc_latch at all times.
- R6: If no detect occurs in cycles 9 through 16, the timer is idle from cycle 17 on with its count cleared. A detect at cycle 17 or later starts a fresh sequence: 8 inhibited cycles, then an 8-cycle observation window.
- R7: While oc_latch is 1 and enable is high, hs_inhibit stays 1 and oc_latch stays 1, and the detect flag has no effect.
- R8: While enable is 0, hs_inhibit is 1 and detects start no sequence. oc_latch is 0 from the first clock edge that sees enable low.
- R9: Detects during cycles 1 through 8 neither extend the skip window nor set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock, one period per switching cycle |
| rst_n | input | 1 | Active-low reset, the supply power-on reset |
| en | input | 1 | Enable. Low disables the drive and clears the latch |
| ilim_det | input | 1 | Current-limit detect flag, sampled at each cycle start |
| hs_inhibit | output | 1 | 1 suppresses the high-side pulse of the current cycle |
| oc_latch | output | 1 | Sticky over-current shutdown latch |
| pg_low_req | output | 1 | Request to force the power-good output low |

## Verification
The cycle count or the phase can go wrong inside the block. The only place that shows it is the cycle in which hs_inhibit changes, or fails to change, relative to the detect cycle. A count that is off by one moves the skip-to-watch edge or the end of the watch window by one cycle. The bench therefore checks hs_inhibit in every cycle of every sequence, so such an error shows at the first cycle it affects. A phase that is stuck or wrongly cleared shows up differently. Either the latch fails to rise on the edge after a watch-window detect, or it rises where it should not, or a new detect after a clean window fails to restart the full sixteen-cycle pattern.

// File: rtl/oc_skip_pkg.sv
package oc_skip_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SKIP  = 2'd1,
    PH_WATCH = 2'd2,
    PH_TRIP  = 2'd3
  } oc_phase_t;

endpackage

// File: rtl/oc_cycle_counter.sv
// Counts switching cycles within one protection sequence.
module oc_cycle_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/oc_phase_fsm.sv
// Sequencer for the protection phases: idle, skip, watch and tripped.
module oc_phase_fsm
  import oc_skip_pkg::*;
#(
  parameter int unsigned SKIP_CYCLES  = 8,
  parameter int unsigned WATCH_CYCLES = 8,
  parameter int unsigned CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             det,
  input  logic [CNT_W-1:0] cnt,
  output oc_phase_t        phase,
  output logic             cnt_clr,
  output logic             cnt_inc
);

  // Cycle index of the last skipped cycle and of the last watched cycle.
  localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(SKIP_CYCLES);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(SKIP_CYCLES + WATCH_CYCLES);

  oc_phase_t phase_nxt;

  always_comb begin
    phase_nxt = phase;
    cnt_clr   = 1'b1;
    cnt_inc   = 1'b0;
    if (!en) begin
      phase_nxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (det) begin
            phase_nxt = PH_SKIP;
            cnt_clr   = 1'b0;
            cnt_inc   = 1'b1;
          end
        end
        PH_SKIP: begin
          cnt_clr = 1'b0;
          cnt_inc = 1'b1;
          if (cnt == SKIP_LAST) begin
            phase_nxt = PH_WATCH;
          end
        end
        PH_WATCH: begin
          if (det) begin
            phase_nxt = PH_TRIP;
          end else if (cnt == WIN_LAST) begin
            phase_nxt = PH_IDLE;
          end else begin
            cnt_clr = 1'b0;
            cnt_inc = 1'b1;
          end
        end
        PH_TRIP: begin
          phase_nxt = PH_TRIP;
        end
        default: begin
          phase_nxt = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_nxt;
    end
  end

endmodule

// File: rtl/oc_drive_gate.sv
// Maps the phase and the live detect flag onto the drive and status outputs.
module oc_drive_gate
  import oc_skip_pkg::*;
(
  input  logic      en,
  input  logic      det,
  input  oc_phase_t phase,
  output logic      hs_inhibit,
  output logic      oc_latch,
  output logic      pg_low_req
);

  logic tripped;
  logic live_hit;

  assign tripped  = (phase == PH_TRIP);
  assign live_hit = det && ((phase == PH_IDLE) || (phase == PH_WATCH));

  always_comb begin
    hs_inhibit = !en || tripped || (phase == PH_SKIP) || live_hit;
    oc_latch   = tripped;
    pg_low_req = tripped;
  end

endmodule

// File: rtl/oc_skip_guard.sv
// Top level of the over-current pulse-skip protection timer.
module oc_skip_guard
  import oc_skip_pkg::*;
#(
  parameter int unsigned SKIP_CYCLES  = 8,
  parameter int unsigned WATCH_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ilim_det,
  output logic hs_inhibit,
  output logic oc_latch,
  output logic pg_low_req
);

  localparam int unsigned SEQ_CYCLES = SKIP_CYCLES + WATCH_CYCLES;
  localparam int unsigned CNT_W      = $clog2(SEQ_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_inc;
  oc_phase_t        phase;

  oc_cycle_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  oc_phase_fsm #(
    .SKIP_CYCLES  (SKIP_CYCLES),
    .WATCH_CYCLES (WATCH_CYCLES),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .det     (ilim_det),
    .cnt     (cnt),
    .phase   (phase),
    .cnt_clr (cnt_clr),
    .cnt_inc (cnt_inc)
  );

  oc_drive_gate u_gate (
    .en         (en),
    .det        (ilim_det),
    .phase      (phase),
    .hs_inhibit (hs_inhibit),
    .oc_latch   (oc_latch),
    .pg_low_req (pg_low_req)
  );

endmodule

// File: rtl/oc_skip_guard_chk.sv
module oc_skip_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ilim_det,
  input logic hs_inhibit,
  input logic oc_latch,
  input logic pg_low_req
);

  p_idle_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ilim_det && !oc_latch) |-> hs_inhibit);

  p_pg_tracks_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pg_low_req == oc_latch);

  p_latch_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_latch) |-> ($past(ilim_det) && $past(en)));

  p_latch_holds_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oc_latch |-> hs_inhibit);

  p_latch_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latch && en) |=> oc_latch);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !oc_latch);

  p_disable_inhibits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> hs_inhibit);

endmodule

bind oc_skip_guard oc_skip_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ilim_det   (ilim_det),
  .hs_inhibit (hs_inhibit),
  .oc_latch   (oc_latch),
  .pg_low_req (pg_low_req)
);

// File: tb/oc_skip_guard_tb.sv
`timescale 1ns/1ps
module oc_skip_guard_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic ilim_det;
  logic hs_inhibit;
  logic oc_latch;
  logic pg_low_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  oc_skip_guard u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ilim_det   (ilim_det),
    .hs_inhibit (hs_inhibit),
    .oc_latch   (oc_latch),
    .pg_low_req (pg_low_req)
  );

  // One switching cycle: drive at the falling edge, sample 1 ns later.
  task automatic cyc(input logic d, input logic e, input logic x_inh,
                     input logic x_lat, input string tag);
    @(negedge clk);
    ilim_det = d;
    en       = e;
    #1;
    checks++;
    if (hs_inhibit !== x_inh) begin
      errors++;
      $display("FAIL %s: hs_inhibit=%0b expected %0b", tag, hs_inhibit, x_inh);
    end
    checks++;
    if (oc_latch !== x_lat) begin
      errors++;
      $display("FAIL %s: oc_latch=%0b expected %0b", tag, oc_latch, x_lat);
    end
    checks++;
    if (pg_low_req !== x_lat) begin
      errors++;
      $display("FAIL %s (R5): pg_low_req=%0b expected %0b", tag, pg_low_req, x_lat);
    end
  endtask

  task automatic skip_phase(input logic d, input string tag);
    for (int i = 1; i <= 8; i++) cyc(d, 1'b1, 1'b1, 1'b0, tag);
  endtask

  task automatic clear_latch();
    cyc(1'b0, 1'b0, 1'b1, 1'b1, "R8 disable cycle, latch still shown");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 latch cleared after enable low");
  endtask

  task automatic t_reset();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R1 reset state");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R1 idle quiet");
  endtask

  task automatic t_clean_window();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 same-cycle inhibit");
    skip_phase(1'b0, "R3 skip window");
    for (int i = 9; i <= 16; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R4 watch window pulses run");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R6 idle after clean window");
  endtask

  task automatic t_fresh_restart();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 first detect");
    skip_phase(1'b0, "R3 skip");
    for (int i = 9; i <= 16; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R4 watch");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R6 detect at cycle 17 restarts");
    skip_phase(1'b0, "R6 fresh skip window");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R6 fresh watch opens at new cycle 9");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R5 detect in fresh watch");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, "R5 latch set after fresh watch detect");
    clear_latch();
  endtask

  task automatic t_trip_first_watch();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 detect");
    skip_phase(1'b0, "R3 skip");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R5 detect at cycle 9 inhibits");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, "R5 latch set after cycle 9");
    for (int i = 0; i < 6; i++) cyc(logic'(i % 2), 1'b1, 1'b1, 1'b1, "R7 latched, detects ignored");
    clear_latch();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 normal after clear");
  endtask

  task automatic t_trip_last_watch();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 detect");
    skip_phase(1'b0, "R3 skip");
    for (int i = 9; i <= 15; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R4 watch");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R5 detect at cycle 16");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, "R5 latch after cycle 16 detect");
    clear_latch();
  endtask

  task automatic t_skip_detects();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 detect");
    skip_phase(1'b1, "R9 detects during skip");
    for (int i = 9; i <= 16; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R9 watch not shifted");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R9 no latch, idle");
  endtask

  task automatic t_disabled();
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, "R8 disabled inhibits, detect ignored");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 no sequence started while disabled");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 still idle");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    en       = 1'b1;
    ilim_det = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean_window();
    t_fresh_restart();
    t_trip_first_watch();
    t_trip_last_watch();
    t_skip_detects();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule